// File: doc/BRIEF.md
# Pipelined Serial Converter Host Controller

This block is the host end of a four-wire serial link (SPI mode 0) to an 8-bit sampling converter. The converter runs with its conversion steps clocked by the serial clock. The controller builds each control byte from a channel selection and three option bits, and it always sets the clock-source bit so that the converter uses the serial clock. It shifts the byte out MSB first and collects each 8-bit result MSB first. Each result leaves on a one-cycle valid strobe, together with the selection and options that produced it, and with a flag that says whether the code is two's complement or straight binary.

The controller has three framings. The fast framing starts a new control byte every 10 serial clocks, and the start bit of each new byte goes out while the previous result is still being read in. The wide framing uses 16 serial clocks per conversion, for hosts that count in whole bytes. The two-byte framing sends one control byte, then eight zero bits that read the result, and then stops. The serial clock half period is a programmable number of system clocks. The controller refuses to start with a half period whose serial clock rate is outside the permitted window. Dropping the run request lets the frame in progress finish, reads its result, and then releases chip select.

Top module: `adc_link_master`

## Requirements
- R1: After reset `cs_n`=1, `sclk`=0, `res_valid`=0, `busy`=0 and `cfg_err`=0.
- R2: While chip select is low, `sclk` is a square wave with a half period of exactly `half_div` system clocks; `sclk` is low whenever `cs_n` is high.
- R3: A start with `half_div` below HALF_LO = ceil(SYS_HZ/(2·SCLK_MAX_HZ)) or above HALF_HI = floor(SYS_HZ/(2·SCLK_MIN_HZ)) leaves `cs_n` high and sets `cfg_err`; a later legal start clears it. The lower rate bound keeps a 16-clock conversion well under 1 ms.
- R4: Each control byte is {1, chan_sel[2:0], 1, ctl_opt[2:0]}, MSB first on the first 8 rising edges of its frame; `mosi` never changes on a rising `sclk` edge.
- R5: With `frame_mode`=00 frames are 10 serial clocks; the result of conversion k is sampled MSB first on the first 8 rising edges of frame k+1, which overlap the next control byte.
- R6: With `frame_mode`=01 frames are 16 serial clocks, with the same result placement as R5.
- R7: With `frame_mode`=1x one conversion runs: 8 clocks of control byte, then 8 clocks that read the result (16 clocks in total); a new one starts only after `run_en` has been low.
- R8: When `run_en` is low at the end of a frame, one 8-clock flush with `mosi`=0 reads the last result, and `cs_n` then rises; a run of N conversions in R5/R6 takes 10N+8 or 16N+8 clocks.
- R9: `res_cfg` = {chan_sel, ctl_opt} of the control byte that produced the result; `res_signed`=1 exactly for chan_sel 011, 010 and 001.
- R10: `res_valid` is a one-cycle pulse, given once per control byte, on the system edge where `sclk` rises for the eighth result bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run request; low asks for a stop |
| frame_mode | input | 2 | 00 fast 10-clock, 01 wide 16-clock, 1x two-byte single shot |
| chan_sel | input | 3 | Input selection field of the control byte |
| ctl_opt | input | 3 | Reference and power option bits of the control byte |
| half_div | input | DIV_W | System clocks per serial clock half period |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result strobe |
| res_data | output | 8 | Conversion code |
| res_cfg | output | 6 | Selection and options of that conversion |
| res_signed | output | 1 | Code is two's complement |
| busy | output | 1 | A transfer or the chip-select gap is in progress |
| cfg_err | output | 1 | Last start was refused for a bad divider |

## Verification
A result is due on the system edge where `sclk` rises for the eighth read bit of the frame after its control byte. In fast mode that frame starts 10 serial clocks, or 20·`half_div` system clocks, after its control byte began; in wide mode it is 16 serial clocks, and in the two-byte mode it is 8 serial clocks. The bench does not wait fixed delays. It follows the serial clock edges, indexes every bit by its position since chip select fell, and takes each strobe into a log away from the clock edge. When chip select has risen, it compares each logged result with the code it drove for that position.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

  typedef enum logic [1:0] {
    FRM_FAST = 2'b00,
    FRM_WIDE = 2'b01,
    FRM_PAIR = 2'b10
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_GAP  = 2'b10
  } seq_state_e;

  // control word: start marker, selection, clock-source bit forced to serial clock, options
  function automatic logic [7:0] build_ctrl(input logic [2:0] sel, input logic [2:0] opt);
    return {1'b1, sel, 1'b1, opt};
  endfunction

  function automatic logic sel_is_signed(input logic [2:0] sel);
    return (sel == 3'b011) || (sel == 3'b010) || (sel == 3'b001);
  endfunction

  // index of the last serial clock of a conversion frame
  function automatic logic [3:0] frame_last(input frame_kind_e kind);
    case (kind)
      FRM_FAST: return 4'd9;
      FRM_WIDE: return 4'd15;
      default:  return 4'd7;
    endcase
  endfunction

endpackage

// File: rtl/adc_link_clkgen.sv
module adc_link_clkgen #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             quiet,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             tick,
  output logic             rise_tk,
  output logic             fall_tk
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;

  assign tick    = en && (cnt_q == half - 1'b1);
  assign rise_tk = tick && !quiet && !sclk_q;
  assign fall_tk = tick && !quiet && sclk_q;
  assign sclk    = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      if (!quiet) sclk_d = !sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk_q);

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && quiet) |=> $stable(sclk_q));

endmodule

// File: rtl/adc_link_shift.sv
module adc_link_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tx_shift,
  input  logic         rx_cap,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_next
);

  logic [W-1:0] tx_q, tx_d, rx_q, rx_d;

  assign mosi    = tx_q[W-1];
  assign rx_next = {rx_q[W-2:0], miso};

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_val;
    else if (tx_shift) tx_d = {tx_q[W-2:0], 1'b0};
    rx_d = rx_cap ? rx_next : rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
  import adc_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] frame_mode,
  input  logic [2:0] chan_sel,
  input  logic [2:0] ctl_opt,
  input  logic       div_ok,
  input  logic       tick,
  input  logic       rise_tk,
  input  logic       fall_tk,
  input  logic [7:0] rx_next,
  output logic       launch,
  output logic       clk_en,
  output logic       quiet,
  output logic       tx_load,
  output logic [7:0] tx_val,
  output logic       tx_shift,
  output logic       rx_cap,
  output logic       cs_n,
  output logic       busy,
  output logic       cfg_err,
  output logic       res_valid,
  output logic [7:0] res_data,
  output logic [5:0] res_cfg,
  output logic       res_signed
);

  seq_state_e  state_q, state_d;
  frame_kind_e kind_q, kind_d, kind_in;
  logic [3:0]  idx_q, idx_d, flen_q, flen_d;
  logic        rd_q, rd_d, flush_q, flush_d, shot_q, shot_d;
  logic        err_q, err_d, csn_q, csn_d;
  logic [5:0]  cur_q, cur_d, pend_q, pend_d;
  logic        vld_q, vld_d, sgn_q, sgn_d;
  logic [7:0]  dat_q, dat_d;
  logic [5:0]  rcfg_q, rcfg_d;
  logic        start_ok, frame_end, res_done;

  always_comb begin
    if (frame_mode[1])      kind_in = FRM_PAIR;
    else if (frame_mode[0]) kind_in = FRM_WIDE;
    else                    kind_in = FRM_FAST;
  end

  assign start_ok  = (state_q == ST_IDLE) && run_en && !shot_q;
  assign frame_end = fall_tk && (idx_q == flen_q);
  assign rx_cap    = rise_tk && rd_q && (idx_q < 4'd8);
  assign res_done  = rx_cap && (idx_q == 4'd7);
  assign tx_shift  = fall_tk && !frame_end;
  assign clk_en    = (state_q != ST_IDLE);
  assign quiet     = (state_q == ST_GAP);
  assign busy      = (state_q != ST_IDLE);
  assign cs_n      = csn_q;
  assign cfg_err   = err_q;
  assign res_valid = vld_q;
  assign res_data  = dat_q;
  assign res_cfg   = rcfg_q;
  assign res_signed = sgn_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    flen_d  = flen_q;
    rd_d    = rd_q;
    flush_d = flush_q;
    shot_d  = shot_q && run_en;
    err_d   = err_q;
    csn_d   = csn_q;
    cur_d   = cur_q;
    pend_d  = pend_q;
    tx_load = 1'b0;
    tx_val  = 8'h00;
    launch  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          if (div_ok) begin
            launch  = 1'b1;
            state_d = ST_RUN;
            csn_d   = 1'b0;
            err_d   = 1'b0;
            kind_d  = kind_in;
            idx_d   = 4'd0;
            flen_d  = frame_last(kind_in);
            rd_d    = 1'b0;
            flush_d = 1'b0;
            cur_d   = {chan_sel, ctl_opt};
            tx_load = 1'b1;
            tx_val  = build_ctrl(chan_sel, ctl_opt);
            shot_d  = (kind_in == FRM_PAIR);
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (fall_tk) begin
          if (!frame_end) begin
            idx_d = idx_q + 4'd1;
          end else if (flush_q) begin
            state_d = ST_GAP;
            csn_d   = 1'b1;
            rd_d    = 1'b0;
          end else begin
            idx_d   = 4'd0;
            rd_d    = 1'b1;
            pend_d  = cur_q;
            tx_load = 1'b1;
            if (kind_q != FRM_PAIR && run_en) begin
              cur_d  = {chan_sel, ctl_opt};
              tx_val = build_ctrl(chan_sel, ctl_opt);
            end else begin
              flush_d = 1'b1;
              flen_d  = 4'd7;
              tx_val  = 8'h00;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    vld_d  = res_done;
    dat_d  = res_done ? rx_next : dat_q;
    rcfg_d = res_done ? pend_q : rcfg_q;
    sgn_d  = res_done ? sel_is_signed(pend_q[5:3]) : sgn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= FRM_FAST;
      idx_q   <= '0;
      flen_q  <= '0;
      rd_q    <= 1'b0;
      flush_q <= 1'b0;
      shot_q  <= 1'b0;
      err_q   <= 1'b0;
      csn_q   <= 1'b1;
      cur_q   <= '0;
      pend_q  <= '0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      rcfg_q  <= '0;
      sgn_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      flen_q  <= flen_d;
      rd_q    <= rd_d;
      flush_q <= flush_d;
      shot_q  <= shot_d;
      err_q   <= err_d;
      csn_q   <= csn_d;
      cur_q   <= cur_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      dat_q   <= dat_d;
      rcfg_q  <= rcfg_d;
      sgn_q   <= sgn_d;
    end
  end

  assert_bad_div_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && run_en && !div_ok) |=> csn_q);

  assert_err_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> csn_q);

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_read_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap |-> !csn_q);

endmodule

// File: rtl/adc_link_master.sv
module adc_link_master
  import adc_link_pkg::*;
#(
  parameter int unsigned SYS_HZ      = 100_000_000,
  parameter int unsigned SCLK_MIN_HZ = 50_000,
  parameter int unsigned SCLK_MAX_HZ = 500_000,
  parameter int unsigned DIV_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       frame_mode,
  input  logic [2:0]       chan_sel,
  input  logic [2:0]       ctl_opt,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             res_valid,
  output logic [7:0]       res_data,
  output logic [5:0]       res_cfg,
  output logic             res_signed,
  output logic             busy,
  output logic             cfg_err
);

  localparam int unsigned HALF_LO = (SYS_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int unsigned HALF_HI = SYS_HZ / (2 * SCLK_MIN_HZ);

  logic [DIV_W-1:0] half_q, half_d;
  logic             div_ok, launch, clk_en, quiet, tick, rise_tk, fall_tk;
  logic             tx_load, tx_shift, rx_cap;
  logic [7:0]       tx_val, rx_next;

  assign div_ok = (32'(half_div) >= HALF_LO) && (32'(half_div) <= HALF_HI) && (HALF_LO > 0);
  assign half_d = launch ? half_div : half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= '0;
    else        half_q <= half_d;
  end

  adc_link_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .quiet(quiet), .half(half_q),
    .sclk(sclk), .tick(tick), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  adc_link_shift #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
    .tx_shift(tx_shift), .rx_cap(rx_cap), .miso(miso),
    .mosi(mosi), .rx_next(rx_next)
  );

  adc_link_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .frame_mode(frame_mode),
    .chan_sel(chan_sel), .ctl_opt(ctl_opt), .div_ok(div_ok),
    .tick(tick), .rise_tk(rise_tk), .fall_tk(fall_tk), .rx_next(rx_next),
    .launch(launch), .clk_en(clk_en), .quiet(quiet),
    .tx_load(tx_load), .tx_val(tx_val), .tx_shift(tx_shift), .rx_cap(rx_cap),
    .cs_n(cs_n), .busy(busy), .cfg_err(cfg_err),
    .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg),
    .res_signed(res_signed)
  );

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  assert_valid_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(sclk));

endmodule

// File: tb/sim_adc_link_master.sv
`timescale 1ns/1ps
module sim_adc_link_master;

  localparam int DW = 12;
  localparam int LO = 10;
  localparam int HI = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic [1:0]    frame_mode = 2'b00;
  logic [2:0]    chan_sel = 3'b000;
  logic [2:0]    ctl_opt = 3'b000;
  logic [DW-1:0] half_div = 12'd10;
  logic          miso = 1'b0;
  logic          sclk, cs_n, mosi, res_valid, res_signed, busy, cfg_err;
  logic [7:0]    res_data;
  logic [5:0]    res_cfg;

  adc_link_master #(.SYS_HZ(10_000_000), .SCLK_MIN_HZ(50_000), .SCLK_MAX_HZ(500_000),
                    .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .frame_mode(frame_mode),
    .chan_sel(chan_sel), .ctl_opt(ctl_opt), .half_div(half_div),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg),
    .res_signed(res_signed), .busy(busy), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pcnt = 0;
  int flen = 10;
  int salt = 0;
  int rises = 0;
  int t_r0 = 0;
  int t_r1 = 0;
  int cs_falls = 0;
  int nres = 0;
  logic mosi_log [0:1023];
  logic [7:0] rd_log [0:63];
  logic [5:0] rc_log [0:63];
  logic       rs_log [0:63];
  logic prev_cs = 1'b1;
  logic prev_sclk = 1'b0;

  function automatic logic [7:0] dev_val(input int k);
    return 8'((k * 73 + salt) & 255);
  endfunction

  function automatic logic dev_bit(input int p);
    int k, j;
    k = p / flen - 1;
    j = p % flen;
    if (k >= 0 && j < 8) begin
      logic [7:0] v;
      v = dev_val(k);
      return v[7 - j];
    end
    return 1'b0;
  endfunction

  function automatic logic exp_signed(input logic [2:0] s);
    return (s == 3'd3) || (s == 3'd2) || (s == 3'd1);
  endfunction

  // converter stand-in and monitor, all sampled on the falling system edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !cs_n) begin
      pcnt = 0;
      cs_falls = cs_falls + 1;
      miso = dev_bit(0);
    end
    if (!prev_sclk && sclk) begin
      if (pcnt < 1024) mosi_log[pcnt] = mosi;
      rises = rises + 1;
      if (rises == 1) t_r0 = cyc;
      if (rises == 2) t_r1 = cyc;
    end
    if (prev_sclk && !sclk) begin
      pcnt = pcnt + 1;
      miso = dev_bit(pcnt);
    end
    if (res_valid && nres < 64) begin
      rd_log[nres] = res_data;
      rc_log[nres] = res_cfg;
      rs_log[nres] = res_signed;
      nres = nres + 1;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_run(input logic [1:0] md, input logic [2:0] sel, input logic [2:0] opt,
                        input int half, input int nfr);
    logic [7:0] ctl;
    int         base, exp_clk, nexp;
    flen = md[1] ? 8 : (md[0] ? 16 : 10);
    nexp = md[1] ? 1 : nfr;
    salt = int'($urandom % 256);
    pcnt = 0; rises = 0; nres = 0;
    for (int i = 0; i < 1024; i++) mosi_log[i] = 1'b0;
    frame_mode = md; chan_sel = sel; ctl_opt = opt; half_div = DW'(half);
    @(negedge clk);
    run_en = 1'b1;
    while (!busy) @(negedge clk);
    if (!md[1]) begin
      while (pcnt < (nfr - 1) * flen + 1) @(negedge clk);
      run_en = 1'b0;
    end
    while (busy) @(negedge clk);
    if (md[1]) begin
      cs_falls = 0;
      wait_cyc(300);
      chk(cs_falls == 0, "R7 no restart while run_en held", cs_falls, 0);
      run_en = 1'b0;
    end
    @(negedge clk);
    ctl = {1'b1, sel, 1'b1, opt};
    exp_clk = md[1] ? 16 : nfr * flen + 8;
    chk(pcnt == exp_clk, "R8 serial clocks in run", pcnt, exp_clk);
    chk(t_r1 - t_r0 == 2 * half, "R2 sclk period", t_r1 - t_r0, 2 * half);
    chk(nres == nexp, "R10 results per control byte", nres, nexp);
    chk(cfg_err == 1'b0, "R3 flag clear after legal start", int'(cfg_err), 0);
    for (int k = 0; k < nexp && k < nres; k++) begin
      logic [7:0] got;
      base = k * flen;
      for (int b = 0; b < 8; b++) got[7 - b] = mosi_log[base + b];
      chk(got == ctl, "R4 control byte", int'(got), int'(ctl));
      chk(rd_log[k] == dev_val(k), md[1] ? "R7 single result" :
          (md[0] ? "R6 wide result" : "R5 fast result"), int'(rd_log[k]), int'(dev_val(k)));
      chk(rc_log[k] == {sel, opt}, "R9 result tag", int'(rc_log[k]), int'({sel, opt}));
      chk(rs_log[k] == exp_signed(sel), "R9 signed flag", int'(rs_log[k]),
          int'(exp_signed(sel)));
    end
    base = md[1] ? 8 : nfr * flen;
    begin
      int ones;
      ones = 0;
      for (int b = 0; b < 8; b++) ones = ones + int'(mosi_log[base + b]);
      chk(ones == 0, "R8 flush bits zero", ones, 0);
    end
  endtask

  task automatic bad_div(input int half);
    half_div = DW'(half);
    frame_mode = 2'b00;
    cs_falls = 0;
    @(negedge clk);
    run_en = 1'b1;
    wait_cyc(200);
    chk(cs_falls == 0, "R3 refused start keeps cs high", cs_falls, 0);
    chk(cfg_err == 1'b1, "R3 error flag", int'(cfg_err), 1);
    run_en = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);

    bad_div(LO - 1);
    bad_div(HI + 1);
    do_run(2'b00, 3'b111, 3'b011, LO, 3);
    bad_div(0);
    do_run(2'b01, 3'b011, 3'b101, HI, 1);
    do_run(2'b10, 3'b001, 3'b111, 12, 1);
    do_run(2'b10, 3'b000, 3'b000, 15, 1);
    do_run(2'b00, 3'b010, 3'b110, 11, 1);

    for (int r = 0; r < 9; r++) begin
      int mi;
      logic [1:0] md;
      mi = int'($urandom % 3);
      md = (mi == 0) ? 2'b00 : ((mi == 1) ? 2'b01 : 2'b10);
      do_run(md, 3'($urandom), 3'($urandom), LO + int'($urandom % 21),
             1 + int'($urandom % 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cyc(190000);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule